// File: doc/BRIEF.md
# Multi-channel prescaled PWM controller

This block is a bank of pulse-width-modulated outputs programmed over a plain 32-bit memory-mapped write/read port. Each channel makes its own tick from one of two clock-source strobes: a fast bus-rate strobe or a slower oscillator strobe. The chosen strobe first passes through a divide-by-2^M stage and then a divide-by-(K+1) stage. A period counter then steps on every tick, and the output is held at its active level for a programmed number of ticks in each period. The active level is selectable per channel.

Two neighbouring channels share one clock-configuration word, which holds the source select and the power-of-two exponent. Each channel has its own control word (prescaler and polarity) and its own period word. A channel runs only while both its gating bit and its enable bit are set. Otherwise it rests at its inactive level, and all of its counters are cleared. Every register write takes effect on the clock edge that captures it, even in the middle of a period.

Top module: `pwm_bank`

## Requirements
- R1: After reset, every register reads back zero, and every output rests high. This is because polarity 0 means active-low, so the inactive level is 1.
- R2: Register map and field positions:
  - Clock-configuration word for channel pair p at 0x20+4*p: bit 7 is the source select and bits [3:0] are the exponent M. Other bits read zero.
  - Gating word at 0x40 and enable word at 0x80: bit n belongs to channel n.
  - Control word at 0x100+0x20*n: bits [7:0] hold K and bit 8 holds the polarity.
  - Period word at 0x104+0x20*n: all 32 bits are kept.
  - Any other offset reads zero.
- R3: When bit 7 of a pair's clock word is 1, the bus strobe drives the pair's channels. When it is 0, the oscillator strobe drives them.
- R4: The first stage divides the source strobes by 2^M. Any M above 8 acts as 8, but reads back exactly as written.
- R5: The second stage divides the first stage's pulses by K+1, where K ranges from 0 to 255.
- R6: The period counter goes from 0 up to the value in period bits [31:16], then wraps to 0. One period therefore lasts that value plus one ticks.
- R7: The channel is active while its count is below period bits [15:0]. A value of 0 keeps the channel inactive. Any value above bits [31:16] keeps it active.
- R8: Bit 8 of the control word set to 1 makes the active level high. Set to 0, it makes the active level low.
- R9: A channel runs only when both its gating bit and its enable bit are 1. While it is not running, its output holds the inactive level.
- R10: Clearing the gating bit or the enable bit zeroes all three of the channel's counters. Running again therefore starts a new period at count 0.
- R11: A write to a running channel's registers acts on the capturing edge. If the count is already at or above a newly written period value, it wraps to 0 on the next tick.
- R12: Channels 2p and 2p+1 both take their source select and exponent from the clock word of pair p.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| oscTick | input | 1 | Single-cycle oscillator source strobe |
| busTick | input | 1 | Single-cycle bus-rate source strobe |
| wrEn | input | 1 | Write strobe, captured on the rising clock edge |
| addr | input | ADDR_W | Byte offset for writes and reads |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data for `addr`, available in the same cycle |
| pwmOut | output | NUM_CH | One PWM output per channel |

## Verification
A write lands on the rising edge that samples `wrEn`. The state it sets (enable, gate, polarity, active count) is visible on `pwmOut` straight after that edge, because the output is decoded from registered state with no extra stage. A change to the period or clock settings shows up only on the next tick. For example, a shrunken period wraps on the tick after the write. Read data depends only on the registers and `addr`, so it is valid in the cycle the address is presented. The bench drives every input on the falling edge and steps its behavioural model on the rising edge. It compares `pwmOut` against the model on every falling edge, and it takes window counts and readbacks at the falling edges that follow those rules.

// File: rtl/pwm_bank_pkg.sv
package pwm_bank_pkg;
  localparam int CNT_W   = 16;          // period / active tick fields
  localparam int PRE_W   = 8;           // prescaler field
  localparam int EXP_W   = 4;           // power-of-two exponent field
  localparam int EXP_MAX = 8;           // largest honoured exponent
  localparam int DIV_W   = EXP_MAX + 1; // divider counter width

  typedef struct packed {
    logic             run;
    logic             srcTick;
    logic [EXP_W-1:0] divExp;
    logic [PRE_W-1:0] preMax;
    logic             activeHigh;
    logic [CNT_W-1:0] perMax;
    logic [CNT_W-1:0] actTicks;
  } chanCtl_t;
endpackage

// File: rtl/pwm_bank_regs.sv
module pwm_bank_regs
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  oscTick,
  input  logic                  busTick,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [31:0]           wrData,
  output logic [31:0]           rdData,
  output chanCtl_t [NUM_CH-1:0] chanCtl
);
  localparam int NUM_PAIR    = (NUM_CH + 1) / 2;
  localparam int CLK_BASE    = 'h20;
  localparam int PAIR_STRIDE = 4;
  localparam int GATE_OFS    = 'h40;
  localparam int EN_OFS      = 'h80;
  localparam int CH_BASE     = 'h100;
  localparam int CH_STRIDE   = 'h20;
  localparam int PER_OFS     = 4;
  localparam int SEL_BIT     = 7;
  localparam int POL_BIT     = PRE_W;
  localparam int CTL_W       = PRE_W + 1;

  logic [NUM_PAIR-1:0]            srcSel;
  logic [NUM_PAIR-1:0][EXP_W-1:0] expRaw;
  logic [NUM_CH-1:0][CTL_W-1:0]   ctlReg;
  logic [NUM_CH-1:0][31:0]        perReg;
  logic [NUM_CH-1:0]              gateReg;
  logic [NUM_CH-1:0]              enReg;

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int ofs);
    return a == ADDR_W'(ofs);
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      srcSel  <= '0;
      expRaw  <= '0;
      ctlReg  <= '0;
      perReg  <= '0;
      gateReg <= '0;
      enReg   <= '0;
    end else if (wrEn) begin
      for (int p = 0; p < NUM_PAIR; p++) begin
        if (hit(addr, CLK_BASE + PAIR_STRIDE * p)) begin
          srcSel[p] <= wrData[SEL_BIT];
          expRaw[p] <= wrData[EXP_W-1:0];
        end
      end
      if (hit(addr, GATE_OFS)) gateReg <= wrData[NUM_CH-1:0];
      if (hit(addr, EN_OFS))   enReg   <= wrData[NUM_CH-1:0];
      for (int c = 0; c < NUM_CH; c++) begin
        if (hit(addr, CH_BASE + CH_STRIDE * c))           ctlReg[c] <= wrData[CTL_W-1:0];
        if (hit(addr, CH_BASE + CH_STRIDE * c + PER_OFS)) perReg[c] <= wrData;
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PAIR; p++) begin
      if (hit(addr, CLK_BASE + PAIR_STRIDE * p)) begin
        rdData[SEL_BIT]     = srcSel[p];
        rdData[EXP_W-1:0]   = expRaw[p];
      end
    end
    if (hit(addr, GATE_OFS)) rdData[NUM_CH-1:0] = gateReg;
    if (hit(addr, EN_OFS))   rdData[NUM_CH-1:0] = enReg;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit(addr, CH_BASE + CH_STRIDE * c))           rdData[CTL_W-1:0] = ctlReg[c];
      if (hit(addr, CH_BASE + CH_STRIDE * c + PER_OFS)) rdData = perReg[c];
    end
  end

  // Per-channel strobe bundle: clamp exponent, pick source from the pair word.
  for (genvar c = 0; c < NUM_CH; c++) begin : g_ctl
    localparam int PAIR = c / 2;
    logic [EXP_W-1:0] expEff;
    assign expEff = (expRaw[PAIR] > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : expRaw[PAIR];
    assign chanCtl[c] = '{
      run:        gateReg[c] & enReg[c],
      srcTick:    srcSel[PAIR] ? busTick : oscTick,
      divExp:     expEff,
      preMax:     ctlReg[c][PRE_W-1:0],
      activeHigh: ctlReg[c][POL_BIT],
      perMax:     perReg[c][2*CNT_W-1:CNT_W],
      actTicks:   perReg[c][CNT_W-1:0]
    };
  end
endmodule

// File: rtl/pwm_bank_chan.sv
module pwm_bank_chan
  import pwm_bank_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  chanCtl_t         cfg,
  output logic             pwmLevel,
  output logic [CNT_W-1:0] perCnt
);
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] divLimit;
  logic [PRE_W-1:0] preCnt;
  logic             divPulse;
  logic             tick;
  logic             active;

  assign divLimit = DIV_W'((32'd1 << cfg.divExp) - 32'd1);
  assign divPulse = cfg.run & cfg.srcTick & (divCnt >= divLimit);
  assign tick     = divPulse & (preCnt >= cfg.preMax);

  // Greater-or-equal wraps let a shrunken limit take hold on the next event.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0;
      preCnt <= '0;
      perCnt <= '0;
    end else if (!cfg.run) begin
      divCnt <= '0;
      preCnt <= '0;
      perCnt <= '0;
    end else begin
      if (cfg.srcTick) divCnt <= (divCnt >= divLimit) ? '0 : divCnt + 1'b1;
      if (divPulse)    preCnt <= (preCnt >= cfg.preMax) ? '0 : preCnt + 1'b1;
      if (tick)        perCnt <= (perCnt >= cfg.perMax) ? '0 : perCnt + 1'b1;
    end
  end

  assign active   = cfg.run & (perCnt < cfg.actTicks);
  assign pwmLevel = cfg.activeHigh ? active : ~active;
endmodule

// File: rtl/pwm_bank.sv
module pwm_bank
  import pwm_bank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              oscTick,
  input  logic              busTick,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wrData,
  output logic [31:0]       rdData,
  output logic [NUM_CH-1:0] pwmOut
);
  chanCtl_t [NUM_CH-1:0]         chanCtl;
  logic [NUM_CH-1:0]             runVec;
  logic [NUM_CH-1:0]             polVec;
  logic [NUM_CH-1:0]             actZero;
  logic [NUM_CH-1:0][CNT_W-1:0]  cntArr;

  pwm_bank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk     (clk),
    .rstN    (rstN),
    .oscTick (oscTick),
    .busTick (busTick),
    .wrEn    (wrEn),
    .addr    (addr),
    .wrData  (wrData),
    .rdData  (rdData),
    .chanCtl (chanCtl)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_bank_chan chan_i (
      .clk      (clk),
      .rstN     (rstN),
      .cfg      (chanCtl[c]),
      .pwmLevel (pwmOut[c]),
      .perCnt   (cntArr[c])
    );
    assign runVec[c]  = chanCtl[c].run;
    assign polVec[c]  = chanCtl[c].activeHigh;
    assign actZero[c] = (chanCtl[c].actTicks == '0);
  end
endmodule

// File: rtl/pwm_bank_chk.sv
module pwm_bank_chk #(
  parameter int NUM_CH = 4,
  parameter int CNT_W  = 16
) (
  input logic                           clk,
  input logic                           rstN,
  input logic [NUM_CH-1:0]              pwmOut,
  input logic [NUM_CH-1:0]              runVec,
  input logic [NUM_CH-1:0]              polVec,
  input logic [NUM_CH-1:0]              actZero,
  input logic [NUM_CH-1:0][CNT_W-1:0]   cntArr
);
  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R9
    idle_level_chk: assert property (@(posedge clk) disable iff (!rstN)
      !runVec[c] |-> pwmOut[c] == ~polVec[c]);

    // R10
    idle_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
      !runVec[c] |=> cntArr[c] == '0);

    // R11
    count_step_chk: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[c] && $past(runVec[c])) |->
        (cntArr[c] == '0) || (cntArr[c] == $past(cntArr[c])) ||
        (cntArr[c] == $past(cntArr[c]) + 1'b1));

    // R7
    zero_active_chk: assert property (@(posedge clk) disable iff (!rstN)
      (runVec[c] && actZero[c]) |-> pwmOut[c] == ~polVec[c]);
  end
endmodule

bind pwm_bank pwm_bank_chk #(.NUM_CH(NUM_CH), .CNT_W(pwm_bank_pkg::CNT_W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .pwmOut  (pwmOut),
  .runVec  (runVec),
  .polVec  (polVec),
  .actZero (actZero),
  .cntArr  (cntArr)
);

// File: tb/pwm_bank_tb_top.sv
`timescale 1ns/1ps
module pwm_bank_tb_top;
  localparam int NCH   = 4;
  localparam int NPAIR = (NCH + 1) / 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        oscTick = 1'b0;
  logic        busTick = 1'b0;
  logic        wrEn = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [NCH-1:0] pwmOut;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;
  bit cmpOn = 1'b0;
  string phaseTag = "R6";

  always #4 clk = ~clk;

  pwm_bank #(.NUM_CH(NCH), .ADDR_W(12)) dut_i (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .busTick(busTick),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData), .pwmOut(pwmOut)
  );

  // Behavioural reference model
  int mDiv[NCH], mPre[NCH], mPer[NCH];
  int mK[NCH], mP[NCH], mA[NCH];
  bit mPol[NCH];
  bit mSel[NPAIR];
  int mExp[NPAIR];
  bit [NCH-1:0] mGate, mEn;

  always @(posedge clk) begin
    bit src;
    int lim;
    if (!rstN) begin
      for (int c = 0; c < NCH; c++) begin
        mDiv[c] = 0; mPre[c] = 0; mPer[c] = 0; mK[c] = 0; mP[c] = 0; mA[c] = 0; mPol[c] = 0;
      end
      for (int p = 0; p < NPAIR; p++) begin mSel[p] = 0; mExp[p] = 0; end
      mGate = '0; mEn = '0;
    end else begin
      for (int c = 0; c < NCH; c++) begin
        if (!(mGate[c] && mEn[c])) begin
          mDiv[c] = 0; mPre[c] = 0; mPer[c] = 0;
        end else begin
          src = mSel[c/2] ? busTick : oscTick;
          lim = (1 << ((mExp[c/2] > 8) ? 8 : mExp[c/2])) - 1;
          if (src) begin
            if (mDiv[c] >= lim) begin
              mDiv[c] = 0;
              if (mPre[c] >= mK[c]) begin
                mPre[c] = 0;
                mPer[c] = (mPer[c] >= mP[c]) ? 0 : mPer[c] + 1;
              end else mPre[c]++;
            end else mDiv[c]++;
          end
        end
      end
      if (wrEn) begin
        for (int p = 0; p < NPAIR; p++)
          if (addr == 12'(32'h20 + 4*p)) begin mSel[p] = wrData[7]; mExp[p] = int'(wrData[3:0]); end
        if (addr == 12'h40) mGate = wrData[NCH-1:0];
        if (addr == 12'h80) mEn = wrData[NCH-1:0];
        for (int c = 0; c < NCH; c++) begin
          if (addr == 12'(32'h100 + 32'h20*c)) begin mK[c] = int'(wrData[7:0]); mPol[c] = wrData[8]; end
          if (addr == 12'(32'h104 + 32'h20*c)) begin mP[c] = int'(wrData[31:16]); mA[c] = int'(wrData[15:0]); end
        end
      end
    end
  end

  // Every-cycle comparison against the model
  always @(negedge clk) begin
    bit act, expv;
    if (rstN && cmpOn && !done) begin
      tests++;
      for (int c = 0; c < NCH; c++) begin
        act  = (mGate[c] && mEn[c]) && (mPer[c] < mA[c]);
        expv = mPol[c] ? act : !act;
        if (pwmOut[c] !== expv) begin
          fails++;
          $display("FAIL %s ch%0d pwmOut actual=%0b expected=%0b", phaseTag, c, pwmOut[c], expv);
        end
      end
    end
  end

  // Source strobes: bus every cycle, oscillator every third cycle
  initial begin
    int cyc = 0;
    forever begin
      @(negedge clk);
      busTick = 1'b1;
      oscTick = (cyc % 3 == 0);
      cyc++;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readCheck(input logic [11:0] a, input logic [31:0] expv, input string tag);
    addr = a;
    #1;
    check(rdData === expv, tag, rdData, expv);
  endtask

  task automatic countHigh(input int ch, input int cycles, output int n);
    n = 0;
    for (int i = 0; i < cycles; i++) begin
      if (pwmOut[ch] === 1'b1) n++;
      @(negedge clk);
    end
  endtask

  task automatic idleAll();
    busWrite(12'h080, 32'h0);
    busWrite(12'h040, 32'h0);
  endtask

  task automatic startCh(input int ch, input logic [31:0] ctl, input logic [31:0] per);
    busWrite(12'(32'h100 + 32'h20*ch), ctl);
    busWrite(12'(32'h104 + 32'h20*ch), per);
    busWrite(12'h040, 32'(1 << ch));
    busWrite(12'h080, 32'(1 << ch));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int n;
    @(negedge clk);
    // R1: outputs rest high during and just after reset
    check(pwmOut === '1, "R1 outputs in reset", 32'(pwmOut), 32'hF);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    cmpOn = 1'b1;
    phaseTag = "R1";
    check(pwmOut === '1, "R1 outputs after reset", 32'(pwmOut), 32'hF);
    readCheck(12'h020, 0, "R1 clock word");
    readCheck(12'h040, 0, "R1 gate word");
    readCheck(12'h080, 0, "R1 enable word");
    readCheck(12'h104, 0, "R1 period word");

    // R2: register map and readback masking
    phaseTag = "R2";
    busWrite(12'h024, 32'hFFFF_FFFF);
    readCheck(12'h024, 32'h8F, "R2 clock word mask");
    busWrite(12'h160, 32'hFFFF_FFFF);
    readCheck(12'h160, 32'h1FF, "R2 control word mask");
    busWrite(12'h164, 32'hDEAD_BEEF);
    readCheck(12'h164, 32'hDEAD_BEEF, "R2 period word");
    busWrite(12'h040, 32'hFFFF_FFFF);
    readCheck(12'h040, 32'hF, "R2 gate word mask");
    readCheck(12'h044, 0, "R2 unmapped 0x44");
    readCheck(12'h108, 0, "R2 unmapped 0x108");
    check(pwmOut[3] === 1'b0, "R9 gated only ch3 idle low", 32'(pwmOut[3]), 0);
    busWrite(12'h040, 0);
    busWrite(12'h024, 0);
    busWrite(12'h160, 0);

    // R5: bus, M=1, K=2, period 4 ticks, active 2 -> 24-cycle period, 12 high
    phaseTag = "R5";
    busWrite(12'h020, 32'h81);
    startCh(0, 32'h102, (32'd3 << 16) | 32'd2);
    countHigh(0, 48, n);
    check(n == 24, "R5 divide chain high count", 32'(n), 24);
    idleAll();

    // R4: M=15 acts as 8: period 2 ticks of 256 cycles, active 1 tick
    phaseTag = "R4";
    busWrite(12'h020, 32'h8F);
    readCheck(12'h020, 32'h8F, "R4 raw exponent readback");
    startCh(0, 32'h100, (32'd1 << 16) | 32'd1);
    countHigh(0, 512, n);
    check(n == 256, "R4 clamped exponent high count", 32'(n), 256);
    idleAll();

    // R3: oscillator strobe every 3 cycles: 12-cycle period, 3 high
    phaseTag = "R3";
    busWrite(12'h020, 32'h00);
    startCh(0, 32'h100, (32'd3 << 16) | 32'd1);
    countHigh(0, 12, n);
    countHigh(0, 24, n);
    check(n == 6, "R3 oscillator source high count", 32'(n), 6);
    idleAll();

    // R6 / R7: period 5 ticks at bus rate; active 0 and active P+1
    phaseTag = "R7";
    busWrite(12'h020, 32'h80);
    startCh(0, 32'h100, (32'd4 << 16) | 32'd0);
    countHigh(0, 20, n);
    check(n == 0, "R7 active 0 never active", 32'(n), 0);
    busWrite(12'h104, (32'd4 << 16) | 32'd5);
    countHigh(0, 20, n);
    check(n == 20, "R7 active above period always active", 32'(n), 20);
    phaseTag = "R6";
    busWrite(12'h104, (32'd4 << 16) | 32'd2);
    countHigh(0, 10, n);
    countHigh(0, 20, n);
    check(n == 8, "R6 period of 5 ticks high count", 32'(n), 8);
    idleAll();

    // R8: inverted polarity, 1 of 4 ticks active low
    phaseTag = "R8";
    startCh(0, 32'h000, (32'd3 << 16) | 32'd1);
    countHigh(0, 8, n);
    check(n == 6, "R8 active-low high count", 32'(n), 6);
    idleAll();

    // R9: enable without gate keeps idle level
    phaseTag = "R9";
    busWrite(12'h100, 32'h100);
    busWrite(12'h104, (32'd3 << 16) | 32'd2);
    busWrite(12'h080, 32'h1);
    countHigh(0, 10, n);
    check(n == 0, "R9 enable without gate idle", 32'(n), 0);
    idleAll();

    // R10: disable mid-period then re-enable starts at count 0
    phaseTag = "R10";
    startCh(0, 32'h100, (32'd9 << 16) | 32'd3);
    repeat (6) @(negedge clk);
    check(pwmOut[0] === 1'b0, "R10 mid-period inactive", 32'(pwmOut[0]), 0);
    busWrite(12'h080, 32'h0);
    busWrite(12'h080, 32'h1);
    countHigh(0, 10, n);
    check(n == 3, "R10 fresh period after re-enable", 32'(n), 3);
    repeat (4) @(negedge clk);
    busWrite(12'h040, 32'h0);
    busWrite(12'h040, 32'h1);
    check(pwmOut[0] === 1'b1, "R10 fresh period after re-gate", 32'(pwmOut[0]), 1);
    idleAll();

    // R11: shrink period mid-run; wrap on the next tick
    phaseTag = "R11";
    startCh(0, 32'h100, (32'd99 << 16) | 32'd50);
    repeat (70) @(negedge clk);
    busWrite(12'h104, (32'd9 << 16) | 32'd5);
    check(pwmOut[0] === 1'b0, "R11 still past active at write edge", 32'(pwmOut[0]), 0);
    @(negedge clk);
    check(pwmOut[0] === 1'b1, "R11 wrap on next tick", 32'(pwmOut[0]), 1);
    idleAll();

    // R12: channel 1 follows pair 0 word (bus), not pair 1 (oscillator)
    phaseTag = "R12";
    busWrite(12'h020, 32'h80);
    busWrite(12'h024, 32'h00);
    startCh(1, 32'h100, (32'd3 << 16) | 32'd2);
    countHigh(1, 8, n);
    check(n == 4, "R12 shared clock word for ch1", 32'(n), 4);
    idleAll();

    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule